// File: doc/BRIEF.md
# TDM PRBS Channel-Window Transmitter

This block sits on the outgoing serial path of a time-division multiplexed stream and overwrites a chosen run of consecutive channels with a 2^15-1 pseudorandom test sequence. Every other channel passes through unchanged. A far-end checker can then measure the bit error rate on that run while live traffic continues on the remaining channels.

The frame has 32 channels of 8 bits each, sent MSB first, so a frame is 256 bit clocks. A frame pulse marks the first bit of channel 0. The window is set by a start channel and a length. It may run past channel 31 and continue at channel 0.

The pseudorandom generator steps once per bit, and only on bits inside the window. Its state is kept from one frame to the next, so the receiver sees one unbroken sequence. Two enables gate the insertion: a per-stream transmit enable and a global transmit enable. Both must be high, and the order in which they are set makes no difference. While either enable is low, the generator sits at its seed. Raising both enables therefore restarts the sequence from its beginning.

Top module: `tdm_prbs_tx`

## Requirements
- R1: While reset is asserted and immediately after it, `ser_o` is 0 and the generator holds the seed 0x7FFF.
- R2: A cycle with `frame_i` high carries the MSB (bit 7) of channel 0. Bit positions then count up by one per clock and wrap after 256 bits. This happens whether or not a frame pulse arrives, and a new pulse at any point realigns the count.
- R3: Channels `start_ch_i`, `start_ch_i`+1, …, `start_ch_i`+`win_len_i`−1, taken modulo 32, carry generator bits. A window that runs past channel 31 continues at channel 0.
- R4: In a bit outside the window, `ser_o` equals the `ser_i` value of the same bit.
- R5: The window is active only while `tx_en_i` and `glob_en_i` are both 1. If either is 0, every bit passes through as in R4.
- R6: The generator is a Fibonacci register s[14:0] for x^15 + x^14 + 1. The bit sent is s[14]. After each bit, s shifts up by one place and s[14]^s[13] enters s[0]. The seed is 0x7FFF, so the first window bit after enabling is 1.
- R7: The generator steps only on window bits. It holds its state on all other bits, across frame boundaries included, so window bits in successive frames continue one sequence.
- R8: While the combined enable is low, the generator is held at the seed. Re-enabling restarts the sequence from its first bit.
- R9: A length of 1 selects exactly one channel. A length of 32 or more selects the whole frame. A length of 0 selects no channel.
- R10: `ser_o` is registered. The bit for the inputs sampled at one rising edge appears after that edge.
- R11: The generator state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | High on the MSB of channel 0 |
| ser_i | input | 1 | Normal serial data |
| start_ch_i | input | 5 | First channel of the window |
| win_len_i | input | 6 | Number of window channels (0 to 32) |
| tx_en_i | input | 1 | Per-stream transmit enable |
| glob_en_i | input | 1 | Global transmit enable |
| ser_o | output | 1 | Outgoing serial data |

## Verification
The bench targets the following corner cases and the error each one would expose:
- **Window wrapping past channel 31.** A design that compares channel numbers without modular arithmetic would send no pattern on channels 0 and 1 of a window starting at 30.
- **Generator continuity across frames.** A generator that stepped on every bit, or reseeded at each frame pulse, would break the sequence at the start of the next window.
- **Zero, single-channel and full-frame lengths.** These show off-by-one errors in the length compare.
- **Disable and re-enable.** If the generator did not reseed while disabled, the restarted sequence would not begin from 0x7FFF.
- **Early frame pulse.** A counter that ignored a pulse arriving mid-frame would place the window in the wrong channels after realignment.

// File: rtl/tdm_prbs_pkg.sv
package tdm_prbs_pkg;
  localparam int unsigned PRBS_W    = 15;
  localparam int unsigned PRBS_TAPA = 14;
  localparam int unsigned PRBS_TAPB = 13;
  localparam logic [PRBS_W-1:0] PRBS_SEED = '1;

  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_TAPA] ^ s[PRBS_TAPB]};
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned CH_BITS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        frame_i,
  input  logic                        en_i,
  input  logic [$clog2(NUM_CH)-1:0]   start_ch_i,
  input  logic [$clog2(NUM_CH):0]     win_len_i,
  output logic                        in_win_o
);
  localparam int unsigned CH_W  = $clog2(NUM_CH);
  localparam int unsigned BIT_W = $clog2(CH_BITS);
  localparam int unsigned POS_W = CH_W + BIT_W;

  logic [POS_W-1:0] pos_q, pos_d;
  logic [CH_W-1:0]  ch_now;
  logic [CH_W-1:0]  ch_off;

  always_comb begin
    pos_d  = frame_i ? '0 : pos_q + 1'b1;
    ch_now = pos_d[POS_W-1:BIT_W];
    ch_off = ch_now - start_ch_i;
    in_win_o = en_i && ({1'b0, ch_off} < win_len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '1;
    else         pos_q <= pos_d;
  end
endmodule

// File: rtl/prbs15_gen.sv
module prbs15_gen
  import tdm_prbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reseed_i,
  input  logic              step_i,
  output logic              bit_o,
  output logic [PRBS_W-1:0] state_o
);
  logic [PRBS_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (reseed_i)    st_d = PRBS_SEED;
    else if (step_i) st_d = prbs_step(st_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PRBS_SEED;
    else         st_q <= st_d;
  end

  assign bit_o   = st_q[PRBS_W-1];
  assign state_o = st_q;
endmodule

// File: rtl/tdm_prbs_tx.sv
module tdm_prbs_tx
  import tdm_prbs_pkg::*;
#(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned CH_BITS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_i,
  input  logic                      ser_i,
  input  logic [$clog2(NUM_CH)-1:0] start_ch_i,
  input  logic [$clog2(NUM_CH):0]   win_len_i,
  input  logic                      tx_en_i,
  input  logic                      glob_en_i,
  output logic                      ser_o
);
  logic              active;
  logic              in_win;
  logic              prbs_bit;
  logic [PRBS_W-1:0] prbs_state;
  logic              ser_d, ser_q;

  assign active = tx_en_i & glob_en_i;

  tdm_slot_timer #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .en_i       (active),
    .start_ch_i (start_ch_i),
    .win_len_i  (win_len_i),
    .in_win_o   (in_win)
  );

  prbs15_gen gen_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reseed_i (~active),
    .step_i   (in_win),
    .bit_o    (prbs_bit),
    .state_o  (prbs_state)
  );

  always_comb ser_d = in_win ? prbs_bit : ser_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ser_q <= 1'b0;
    else         ser_q <= ser_d;
  end

  assign ser_o = ser_q;
endmodule

// File: rtl/tdm_prbs_tx_chk.sv
module tdm_prbs_tx_chk
  import tdm_prbs_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      frame_i,
  input logic                      ser_i,
  input logic [$clog2(NUM_CH)-1:0] start_ch_i,
  input logic [$clog2(NUM_CH):0]   win_len_i,
  input logic                      tx_en_i,
  input logic                      glob_en_i,
  input logic                      ser_o,
  input logic                      in_win,
  input logic [PRBS_W-1:0]         prbs_state
);
  // R4, R5, R10
  a_r4_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |=> ser_o == $past(ser_i));
  // R5: no window while either enable is low
  a_r5_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_en_i && glob_en_i) |-> !in_win);
  // R7: generator holds outside the window
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && glob_en_i && !in_win) |=> $stable(prbs_state));
  // R8: reseed while disabled
  a_r8_reseed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_en_i && glob_en_i) |=> prbs_state == PRBS_SEED);
  // R2: frame pulse lands in channel 0
  a_r2_frame_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && tx_en_i && glob_en_i && start_ch_i == '0 && win_len_i != '0) |-> in_win);
  // R11
  a_r11_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prbs_state != '0);
endmodule

bind tdm_prbs_tx tdm_prbs_tx_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .ser_i      (ser_i),
  .start_ch_i (start_ch_i),
  .win_len_i  (win_len_i),
  .tx_en_i    (tx_en_i),
  .glob_en_i  (glob_en_i),
  .ser_o      (ser_o),
  .in_win     (in_win),
  .prbs_state (prbs_state)
);

// File: tb/tdm_prbs_tx_tb_top.sv
`timescale 1ns/1ps
module tdm_prbs_tx_tb_top;
  localparam int CLK_NS = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       frame_i;
  logic       ser_i;
  logic [4:0] start_ch_i;
  logic [5:0] win_len_i;
  logic       tx_en_i;
  logic       glob_en_i;
  logic       ser_o;

  int n_chk  = 0;
  int n_fail = 0;

  int mpos;
  int mst;

  always #(CLK_NS/2) clk_i = ~clk_i;

  tdm_prbs_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .ser_i(ser_i),
    .start_ch_i(start_ch_i), .win_len_i(win_len_i), .tx_en_i(tx_en_i),
    .glob_en_i(glob_en_i), .ser_o(ser_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_o=%b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  // one bit clock; called just after a falling edge
  task automatic bit_cycle(input logic fp, input string req);
    int  pos, ch, off;
    logic act, inw, exp, din;
    din = 1'($urandom);
    frame_i = fp;
    ser_i   = din;
    pos = fp ? 0 : (mpos + 1) % 256;
    ch  = pos / 8;
    off = (ch - int'(start_ch_i) + 32) % 32;
    act = tx_en_i && glob_en_i;
    inw = act && (off < int'(win_len_i));
    exp = inw ? 1'(mst >> 14) : din;
    if (!act) mst = 32'h7FFF;
    else if (inw) mst = ((mst << 1) & 32'h7FFF) | (((mst >> 14) ^ (mst >> 13)) & 1);
    mpos = pos;
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, ser_o, exp);
  endtask

  task automatic run_frames(input int n, input string req);
    for (int i = 0; i < n * 256; i++) bit_cycle(mpos == 255, req);
  endtask

  task automatic set_win(input int s, input int l);
    start_ch_i = 5'(s);
    win_len_i  = 6'(l);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; frame_i = 0; ser_i = 0; tx_en_i = 0; glob_en_i = 0;
    set_win(0, 1);
    mpos = 255; mst = 32'h7FFF;
    repeat (3) @(negedge clk_i);
    check("R1", ser_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", ser_o, 1'b0);
  endtask

  task automatic t_disabled;
    set_win(0, 32);
    tx_en_i = 0; glob_en_i = 1;
    run_frames(1, "R5");
    tx_en_i = 1; glob_en_i = 0;
    run_frames(1, "R5");
  endtask

  task automatic t_mid_window;
    set_win(5, 3);
    tx_en_i = 1; glob_en_i = 1;
    run_frames(3, "R3_R4_R6_R7");
  endtask

  task automatic t_single;
    tx_en_i = 0; bit_cycle(mpos == 255, "R8");
    set_win(17, 1); tx_en_i = 1;
    run_frames(2, "R9_single");
  endtask

  task automatic t_full;
    set_win(9, 32);
    run_frames(2, "R9_full_R7");
    set_win(0, 40);
    run_frames(1, "R9_over");
  endtask

  task automatic t_zero;
    set_win(4, 0);
    run_frames(1, "R9_zero");
  endtask

  task automatic t_wrap;
    set_win(30, 4);
    run_frames(2, "R3_wrap");
  endtask

  task automatic t_reseed;
    set_win(2, 2);
    glob_en_i = 0;
    run_frames(1, "R8_off");
    glob_en_i = 1;
    run_frames(2, "R8_restart");
  endtask

  task automatic t_realign;
    set_win(0, 2);
    for (int i = 0; i < 77; i++) bit_cycle(1'b0, "R2");
    bit_cycle(1'b1, "R2_early");
    run_frames(2, "R2_realign");
    for (int i = 0; i < 300; i++) bit_cycle(1'b0, "R2_freerun");
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_mid_window();
    t_single();
    t_full();
    t_zero();
    t_wrap();
    t_reseed();
    t_realign();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule